// File: doc/BRIEF.md
# Shifted-Operand ALU with Condition Flags

This block is the data-processing stage of a 32-bit datapath, and it is purely combinational. The first operand comes straight from a register read port. The second operand is either an immediate value or a register value that first goes through a barrel shifter. The shifter can apply a logical left, logical right, arithmetic right or rotate-right shift by 0 to 31 positions. It can also rotate right by one through the carry flag.

The block performs move, inverted move, add, subtract, reverse subtract, AND, OR, XOR and bit-clear. It also has four flag-only operations: compare, compare-negative, test and test-equivalence. It produces a result word, a strobe that says whether the result should be written back, and the next value of the N, Z, C and V flags. The surrounding pipeline feeds the current flags in and registers the outputs.

Top module: `dp_shift_alu`

## Requirements
- R1: The first operand `rn_i` reaches the arithmetic and logic stage unshifted. Only the second operand is shifted. Example: ADD of 5 and 5 shifted left by one gives 0x0000000F.
- R2: With `shift_kind_i`=0 (logical left) and amount y from 1 to 31, the operand becomes `rm_i << y` and the shifter carry becomes bit (32−y) of `rm_i`.
- R3: With `shift_kind_i`=1 (logical right) or 2 (arithmetic right) and amount y from 1 to 31, the shifter carry is bit (y−1) of `rm_i`. Arithmetic right fills the vacated bits with bit 31.
- R4: With `shift_kind_i`=3 (rotate right), the operand is rotated and the carry is bit 31 of the rotated word. With `shift_kind_i`=4, the amount is ignored: the operand moves right by one, the incoming C enters bit 31, and bit 0 leaves as the carry.
- R5: A shift amount of zero with kinds 0 to 3 passes `rm_i` through unchanged and keeps the incoming C as the shifter carry. When `op2_imm_i`=1, `imm_i` is used unshifted and the shifter carry is the incoming C.
- R6: The logical operation codes are: AND=0, XOR=1, OR=8, MOVE=9, BIT-CLEAR=10 (`rn_i` AND NOT operand), MOVE-NOT=11 (NOT operand). Each writes its result with `result_we_o`=1.
- R7: The arithmetic operation codes are: SUB=2 (`rn_i`−operand), RSB=3 (operand−`rn_i`), ADD=4. Each writes its result. Example: RSB of 0x77 from 0 gives 0xFFFFFF89.
- R8: The flag word is {N,Z,C,V} in bits [3:0]. When a logical operation or a test updates flags, N is result bit 31, Z means the result is all zeros, C is the shifter carry, and V is kept.
- R9: When an arithmetic operation or a compare updates flags, C is the adder carry-out (for subtraction this means no borrow) and V is signed two's-complement overflow. Example: 1−1 sets Z and C.
- R10: The flag-only codes are: TST=5 (AND), TEQ=6 (XOR), CMP=7 (subtract), CMN=12 (add). They always update flags, whatever `set_flags_i` says, and they hold `result_we_o` at 0.
- R11: For codes 0 to 4 and 8 to 11, when `set_flags_i`=0, `flags_o` equals `flags_i`.
- R12: Codes 13 to 15 are reserved. They hold `result_we_o` at 0 and pass `flags_i` through unchanged.
- R13: `shift_kind_i` codes 5 to 7 behave as no shift: the operand passes through and the incoming C is kept as the shifter carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rn_i | input | 32 | First operand, never shifted |
| rm_i | input | 32 | Register operand feeding the shifter |
| imm_i | input | 32 | Immediate second operand |
| op2_imm_i | input | 1 | 1 selects the immediate, 0 selects the shifted register |
| shift_kind_i | input | 3 | Shift type code |
| shift_amt_i | input | 5 | Shift distance, 0 to 31 |
| op_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Request a flag update for non-compare operations |
| flags_i | input | 4 | Current {N,Z,C,V} |
| result_o | output | 32 | Operation result |
| result_we_o | output | 1 | Result write strobe |
| flags_o | output | 4 | Next {N,Z,C,V} |

## Verification
The bench sweeps every left and right shift distance, so an off-by-one in the carry tap shows up as a wrong C on some distance. It covers zero-distance and immediate operands, where a design that drops the carry-in would clear C. It covers signed overflow and borrow cases for add and subtract, where an inverted carry sense would misreport 1−1 or a subtraction that borrows. It also covers the flag-only and reserved codes with `set_flags_i` low, so a design that writes results for compares, or gates compare flags on the set-flags input, gives a wrong strobe or stale flags.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_TST = 4'd5,  OP_TEQ = 4'd6,  OP_CMP = 4'd7,
    OP_ORR = 4'd8,  OP_MOV = 4'd9,  OP_BIC = 4'd10, OP_MVN = 4'd11,
    OP_CMN = 4'd12, OP_RS13 = 4'd13, OP_RS14 = 4'd14, OP_RS15 = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    SH_LSL = 3'd0, SH_LSR = 3'd1, SH_ASR = 3'd2, SH_ROR = 3'd3, SH_RRX = 3'd4
  } shift_e;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_LOGIC = 2'd1,
    CLS_ARITH = 2'd2
  } op_class_e;

  typedef enum logic [1:0] {
    AF_ADD = 2'd0,
    AF_SUB = 2'd1,
    AF_RSB = 2'd2
  } add_form_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  typedef struct packed {
    op_class_e cls;
    add_form_e form;
    logic      writes;
    logic      flags_always;
  } op_ctrl_t;

  function automatic op_ctrl_t decode_op(alu_op_e op);
    op_ctrl_t c;
    c = '{cls: CLS_NONE, form: AF_ADD, writes: 1'b0, flags_always: 1'b0};
    case (op)
      OP_AND, OP_EOR, OP_ORR, OP_MOV, OP_BIC, OP_MVN: begin
        c.cls = CLS_LOGIC; c.writes = 1'b1;
      end
      OP_TST, OP_TEQ: begin
        c.cls = CLS_LOGIC; c.flags_always = 1'b1;
      end
      OP_ADD: begin c.cls = CLS_ARITH; c.writes = 1'b1; end
      OP_SUB: begin c.cls = CLS_ARITH; c.form = AF_SUB; c.writes = 1'b1; end
      OP_RSB: begin c.cls = CLS_ARITH; c.form = AF_RSB; c.writes = 1'b1; end
      OP_CMP: begin c.cls = CLS_ARITH; c.form = AF_SUB; c.flags_always = 1'b1; end
      OP_CMN: begin c.cls = CLS_ARITH; c.flags_always = 1'b1; end
      default: c = '{cls: CLS_NONE, form: AF_ADD, writes: 1'b0, flags_always: 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/dp_barrel_shifter.sv
module dp_barrel_shifter
  import dp_alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  opnd_i,
  input  logic [2:0]    kind_i,
  input  logic [AW-1:0] amt_i,
  input  logic          cin_i,
  output logic [W-1:0]  opnd_o,
  output logic          cout_o
);

  // Left shift with the bit falling off the top kept at index W.
  function automatic logic [W:0] f_lsl(logic [W-1:0] v, logic [AW-1:0] n);
    return {1'b0, v} << n;
  endfunction

  // Right shift with the bit falling off the bottom kept at index 0.
  function automatic logic [W:0] f_lsr(logic [W-1:0] v, logic [AW-1:0] n);
    return {v, 1'b0} >> n;
  endfunction

  function automatic logic [W:0] f_asr(logic [W-1:0] v, logic [AW-1:0] n);
    return $signed({v, 1'b0}) >>> n;
  endfunction

  function automatic logic [W-1:0] f_ror(logic [W-1:0] v, logic [AW-1:0] n);
    logic [2*W-1:0] d;
    d = {v, v} >> n;
    return d[W-1:0];
  endfunction

  logic [W:0]   lsl_w, lsr_w, asr_w;
  logic [W-1:0] ror_w;
  logic         amt_zero;

  assign lsl_w    = f_lsl(opnd_i, amt_i);
  assign lsr_w    = f_lsr(opnd_i, amt_i);
  assign asr_w    = f_asr(opnd_i, amt_i);
  assign ror_w    = f_ror(opnd_i, amt_i);
  assign amt_zero = (amt_i == '0);

  always_comb begin
    opnd_o = opnd_i;
    cout_o = cin_i;
    if (kind_i == SH_RRX) begin
      opnd_o = {cin_i, opnd_i[W-1:1]};
      cout_o = opnd_i[0];
    end else if (!amt_zero) begin
      case (kind_i)
        SH_LSL: begin opnd_o = lsl_w[W-1:0]; cout_o = lsl_w[W]; end
        SH_LSR: begin opnd_o = lsr_w[W:1];   cout_o = lsr_w[0]; end
        SH_ASR: begin opnd_o = asr_w[W:1];   cout_o = asr_w[0]; end
        SH_ROR: begin opnd_o = ror_w;        cout_o = ror_w[W-1]; end
        default: begin opnd_o = opnd_i;      cout_o = cin_i; end
      endcase
    end
  end

  always_comb begin
    // R3
    asr_sign_chk: assert (!(kind_i == SH_ASR) || (opnd_o[W-1] == opnd_i[W-1]))
      else $error("arithmetic shift lost the sign bit");
    // R4
    ror_pop_chk: assert (!(kind_i == SH_ROR) || ($countones(opnd_o) == $countones(opnd_i)))
      else $error("rotate changed the population count");
    // R2
    lsl_fill_chk: assert (!(kind_i == SH_LSL && !amt_zero) || (opnd_o[0] == 1'b0))
      else $error("left shift did not clear bit 0");
  end

endmodule

// File: rtl/dp_addsub.sv
module dp_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);

  function automatic logic [W:0] f_add(logic [W-1:0] a, logic [W-1:0] b, logic c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  function automatic logic f_ovf(logic sa, logic sb, logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  logic [W:0] full_w;

  assign full_w = f_add(x_i, y_i, cin_i);
  assign sum_o  = full_w[W-1:0];
  assign cout_o = full_w[W];
  assign ovf_o  = f_ovf(x_i[W-1], y_i[W-1], full_w[W-1]);

  always_comb begin
    // R9
    ovf_sign_chk: assert (!ovf_o || (sum_o[W-1] != x_i[W-1]))
      else $error("overflow reported without sign change");
  end

endmodule

// File: rtl/dp_logic_unit.sv
module dp_logic_unit
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);

  always_comb begin
    case (op_i)
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
      OP_ORR:         res_o = a_i | b_i;
      OP_MOV:         res_o = b_i;
      OP_BIC:         res_o = a_i & ~b_i;
      OP_MVN:         res_o = ~b_i;
      default:        res_o = '0;
    endcase
  end

  always_comb begin
    // R6
    bic_clear_chk: assert (!(op_i == OP_BIC) || ((res_o & b_i) == '0))
      else $error("bit-clear left a masked bit set");
  end

endmodule

// File: rtl/dp_flag_unit.sv
module dp_flag_unit
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  op_class_e    cls_i,
  input  logic         upd_i,
  input  logic [W-1:0] res_i,
  input  logic         shc_i,
  input  logic         ac_i,
  input  logic         av_i,
  input  nzcv_t        flags_i,
  output nzcv_t        flags_o
);

  always_comb begin
    flags_o = flags_i;
    if (upd_i) begin
      flags_o.n = res_i[W-1];
      flags_o.z = (res_i == '0);
      case (cls_i)
        CLS_LOGIC: flags_o.c = shc_i;
        CLS_ARITH: begin flags_o.c = ac_i; flags_o.v = av_i; end
        default:   flags_o = flags_i;
      endcase
    end
  end

  always_comb begin
    // R8
    logic_v_hold_chk: assert (!(cls_i == CLS_LOGIC) || (flags_o.v == flags_i.v))
      else $error("logical class disturbed V");
  end

endmodule

// File: rtl/dp_shift_alu.sv
module dp_shift_alu
  import dp_alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  rn_i,
  input  logic [W-1:0]  rm_i,
  input  logic [W-1:0]  imm_i,
  input  logic          op2_imm_i,
  input  logic [2:0]    shift_kind_i,
  input  logic [AW-1:0] shift_amt_i,
  input  logic [3:0]    op_i,
  input  logic          set_flags_i,
  input  logic [3:0]    flags_i,
  output logic [W-1:0]  result_o,
  output logic          result_we_o,
  output logic [3:0]    flags_o
);

  alu_op_e      op_w;
  op_ctrl_t     ctrl_w;
  nzcv_t        fin_w, fout_w;
  logic [W-1:0] shifted_w, op2_w, logic_res_w, sum_w;
  logic [W-1:0] add_x_w, add_y_w;
  logic         add_cin_w, add_c_w, add_v_w;
  logic         sh_c_w, op2_c_w, flag_upd_w;

  assign op_w   = alu_op_e'(op_i);
  assign ctrl_w = decode_op(op_w);
  assign fin_w  = nzcv_t'(flags_i);

  dp_barrel_shifter #(.W(W), .AW(AW)) u_shift (
    .opnd_i (rm_i),
    .kind_i (shift_kind_i),
    .amt_i  (shift_amt_i),
    .cin_i  (fin_w.c),
    .opnd_o (shifted_w),
    .cout_o (sh_c_w)
  );

  assign op2_w   = op2_imm_i ? imm_i   : shifted_w;
  assign op2_c_w = op2_imm_i ? fin_w.c : sh_c_w;

  always_comb begin
    case (ctrl_w.form)
      AF_SUB:  begin add_x_w = rn_i;  add_y_w = ~op2_w; add_cin_w = 1'b1; end
      AF_RSB:  begin add_x_w = op2_w; add_y_w = ~rn_i;  add_cin_w = 1'b1; end
      default: begin add_x_w = rn_i;  add_y_w = op2_w;  add_cin_w = 1'b0; end
    endcase
  end

  dp_addsub #(.W(W)) u_add (
    .x_i    (add_x_w),
    .y_i    (add_y_w),
    .cin_i  (add_cin_w),
    .sum_o  (sum_w),
    .cout_o (add_c_w),
    .ovf_o  (add_v_w)
  );

  dp_logic_unit #(.W(W)) u_logic (
    .op_i  (op_w),
    .a_i   (rn_i),
    .b_i   (op2_w),
    .res_o (logic_res_w)
  );

  assign result_o    = (ctrl_w.cls == CLS_ARITH) ? sum_w : logic_res_w;
  assign result_we_o = ctrl_w.writes;
  assign flag_upd_w  = (ctrl_w.cls != CLS_NONE) && (set_flags_i || ctrl_w.flags_always);

  dp_flag_unit #(.W(W)) u_flags (
    .cls_i   (ctrl_w.cls),
    .upd_i   (flag_upd_w),
    .res_i   (result_o),
    .shc_i   (op2_c_w),
    .ac_i    (add_c_w),
    .av_i    (add_v_w),
    .flags_i (fin_w),
    .flags_o (fout_w)
  );

  assign flags_o = fout_w;

  always_comb begin
    // R10
    cmp_no_write_chk: assert (!(op_w inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN}) || !result_we_o)
      else $error("flag-only operation asserted the write strobe");
    // R11
    flags_hold_chk: assert (set_flags_i || ctrl_w.flags_always || (flags_o == flags_i))
      else $error("flags moved without a set-flags request");
    // R12
    reserved_op_chk: assert (!(op_i >= 4'd13) || (!result_we_o && (flags_o == flags_i)))
      else $error("reserved code had an effect");
    // R9
    sub_borrow_chk: assert (!(ctrl_w.cls == CLS_ARITH && ctrl_w.form == AF_SUB) ||
                            (add_c_w == (rn_i >= op2_w)))
      else $error("subtract carry does not match no-borrow");
  end

endmodule

// File: tb/tb_dp_shift_alu.sv
module tb_dp_shift_alu;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] rn, rm, imm, res;
  logic        isel, sf, we;
  logic [2:0]  kind;
  logic [4:0]  amt;
  logic [3:0]  op, fin, fout;

  dp_shift_alu dut (
    .rn_i(rn), .rm_i(rm), .imm_i(imm), .op2_imm_i(isel),
    .shift_kind_i(kind), .shift_amt_i(amt), .op_i(op),
    .set_flags_i(sf), .flags_i(fin),
    .result_o(res), .result_we_o(we), .flags_o(fout)
  );

  typedef struct packed {
    logic [31:0] rn; logic [31:0] rm; logic [31:0] imm; logic isel;
    logic [2:0] kind; logic [4:0] amt; logic [3:0] op; logic sf; logic [3:0] fin;
    logic [31:0] eres; logic ewe; logic [3:0] eflg; logic [7:0] req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{32'h0, 32'h80000004, 32'h0, 1'b0, 3'd0, 5'd1, 4'd9, 1'b1, 4'h0, 32'h00000008, 1'b1, 4'h2, 8'd2},   // R2
    '{32'h5, 32'h5, 32'h0, 1'b0, 3'd0, 5'd1, 4'd4, 1'b0, 4'h0, 32'h0000000F, 1'b1, 4'h0, 8'd1},          // R1
    '{32'h77, 32'h0, 32'h0, 1'b1, 3'd0, 5'd0, 4'd3, 1'b1, 4'h0, 32'hFFFFFF89, 1'b1, 4'h8, 8'd7},         // R7
    '{32'h1, 32'h0, 32'h1, 1'b1, 3'd0, 5'd0, 4'd2, 1'b1, 4'h0, 32'h0, 1'b1, 4'h6, 8'd9},                 // R9
    '{32'h4, 32'h0, 32'h4, 1'b1, 3'd0, 5'd0, 4'd7, 1'b0, 4'h0, 32'h0, 1'b0, 4'h6, 8'd10},                // R10
    '{32'h02040608, 32'h10305070, 32'h0, 1'b0, 3'd0, 5'd0, 4'd8, 1'b0, 4'h0, 32'h12345678, 1'b1, 4'h0, 8'd6}, // R6
    '{32'hF, 32'h5, 32'h0, 1'b0, 3'd0, 5'd0, 4'd10, 1'b0, 4'h0, 32'hA, 1'b1, 4'h0, 8'd6},                // R6
    '{32'h0, 32'h0, 32'h0, 1'b1, 3'd0, 5'd0, 4'd11, 1'b1, 4'h0, 32'hFFFFFFFF, 1'b1, 4'h8, 8'd6},         // R6
    '{32'h0, 32'h3, 32'h0, 1'b0, 3'd1, 5'd1, 4'd9, 1'b1, 4'h0, 32'h1, 1'b1, 4'h2, 8'd3},                 // R3
    '{32'h0, 32'h80000000, 32'h0, 1'b0, 3'd2, 5'd4, 4'd9, 1'b1, 4'h1, 32'hF8000000, 1'b1, 4'h9, 8'd3},   // R3
    '{32'h0, 32'h1, 32'h0, 1'b0, 3'd3, 5'd1, 4'd9, 1'b1, 4'h0, 32'h80000000, 1'b1, 4'hA, 8'd4},          // R4
    '{32'h0, 32'h2, 32'h0, 1'b0, 3'd4, 5'd7, 4'd9, 1'b1, 4'h2, 32'h80000001, 1'b1, 4'h8, 8'd4},          // R4
    '{32'h0, 32'h12345678, 32'h0, 1'b0, 3'd0, 5'd0, 4'd9, 1'b1, 4'h2, 32'h12345678, 1'b1, 4'h2, 8'd5},   // R5
    '{32'h7FFFFFFF, 32'h0, 32'h1, 1'b1, 3'd0, 5'd0, 4'd4, 1'b1, 4'h0, 32'h80000000, 1'b1, 4'h9, 8'd9},   // R9
    '{32'hFFFFFFFF, 32'h0, 32'h1, 1'b1, 3'd0, 5'd0, 4'd4, 1'b1, 4'h0, 32'h0, 1'b1, 4'h6, 8'd9},          // R9
    '{32'h80000000, 32'h0, 32'h1, 1'b1, 3'd0, 5'd0, 4'd2, 1'b1, 4'h0, 32'h7FFFFFFF, 1'b1, 4'h3, 8'd9},   // R9
    '{32'hF0, 32'h0, 32'hF, 1'b1, 3'd0, 5'd0, 4'd5, 1'b0, 4'h1, 32'h0, 1'b0, 4'h5, 8'd10},               // R10
    '{32'h80000000, 32'h3, 32'h0, 1'b0, 3'd0, 5'd31, 4'd6, 1'b0, 4'h0, 32'h0, 1'b0, 4'h6, 8'd10},        // R10
    '{32'hFFFFFFFF, 32'h0, 32'h1, 1'b1, 3'd0, 5'd0, 4'd12, 1'b0, 4'h0, 32'h0, 1'b0, 4'h6, 8'd10},        // R10
    '{32'h0, 32'h0, 32'h0, 1'b1, 3'd0, 5'd0, 4'd4, 1'b0, 4'hB, 32'h0, 1'b1, 4'hB, 8'd11},                // R11
    '{32'h1, 32'h0, 32'h1, 1'b1, 3'd0, 5'd0, 4'd13, 1'b1, 4'h5, 32'h0, 1'b0, 4'h5, 8'd12},               // R12
    '{32'h0, 32'h0, 32'h0, 1'b1, 3'd0, 5'd0, 4'd15, 1'b1, 4'hA, 32'h0, 1'b0, 4'hA, 8'd12},               // R12
    '{32'hFFFF0000, 32'h0000FFFF, 32'h0, 1'b0, 3'd0, 5'd0, 4'd1, 1'b1, 4'h3, 32'hFFFFFFFF, 1'b1, 4'hB, 8'd8}, // R8
    '{32'h2, 32'h1, 32'h0, 1'b0, 3'd0, 5'd0, 4'd2, 1'b1, 4'h0, 32'h1, 1'b1, 4'h2, 8'd7},                 // R7
    '{32'hFFFFFFFF, 32'h1, 32'h0, 1'b0, 3'd1, 5'd1, 4'd0, 1'b1, 4'h1, 32'h0, 1'b1, 4'h7, 8'd8},          // R8
    '{32'h0, 32'hDEADBEEF, 32'h80000000, 1'b1, 3'd2, 5'd4, 4'd9, 1'b1, 4'h2, 32'h80000000, 1'b1, 4'hA, 8'd5}, // R5
    '{32'h0, 32'h10, 32'h0, 1'b0, 3'd6, 5'd3, 4'd9, 1'b1, 4'h2, 32'h10, 1'b1, 4'h2, 8'd13}               // R13
  };

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic apply(input vec_t v);
    @(posedge clk);
    #2;
    rn = v.rn; rm = v.rm; imm = v.imm; isel = v.isel; kind = v.kind;
    amt = v.amt; op = v.op; sf = v.sf; fin = v.fin;
    #8;
  endtask

  task automatic judge(input string tag, input vec_t v);
    checks++;
    if (we !== v.ewe || fout !== v.eflg || (v.ewe && res !== v.eres)) begin
      fails++;
      $display("FAIL %s: res=%h we=%b flags=%h, expected res=%h we=%b flags=%h",
               tag, res, we, fout, v.eres, v.ewe, v.eflg);
    end
  endtask

  initial begin
    vec_t v;
    rn = '0; rm = '0; imm = '0; isel = 1'b0; kind = '0; amt = '0;
    op = '0; sf = 1'b0; fin = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state after reset: AND of zeros, no flag update (R6, R11)
    v = '{32'h0, 32'h0, 32'h0, 1'b0, 3'd0, 5'd0, 4'd0, 1'b0, 4'h0, 32'h0, 1'b1, 4'h0, 8'd6};
    apply(v);
    judge("R6 idle reset state", v);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      judge($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i]);
    end

    // R2: sweep every left-shift distance
    for (int y = 1; y < 32; y++) begin
      logic [31:0] src, exp_r;
      src = 32'hA5A5_A5A5;
      exp_r = src << y;
      v = '{32'h0, src, 32'h0, 1'b0, 3'd0, 5'(y), 4'd9, 1'b1, 4'h0,
            exp_r, 1'b1, {exp_r[31], exp_r == 32'h0, src[32-y], 1'b0}, 8'd2};
      apply(v);
      judge($sformatf("R2 lsl by %0d", y), v);
    end

    // R3: sweep every logical right-shift distance
    for (int y = 1; y < 32; y++) begin
      logic [31:0] src, exp_r;
      src = 32'h9C3E_1B67;
      exp_r = src >> y;
      v = '{32'h0, src, 32'h0, 1'b0, 3'd1, 5'(y), 4'd9, 1'b1, 4'h1,
            exp_r, 1'b1, {exp_r[31], exp_r == 32'h0, src[y-1], 1'b1}, 8'd3};
      apply(v);
      judge($sformatf("R3 lsr by %0d", y), v);
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule